// File: doc/BRIEF.md
# Host Command and Status Register Unit

This block is the host-facing register set of a packet controller. The host uses a 32-bit register bus with byte enables. It sees a 16-bit status word, a 16-bit command word and a 32-bit general pointer. A command code written into the command word is passed to the command unit or the receive unit over a valid/accept handshake. The field clears once the unit has taken the code, so software can poll for a zero field before it issues the next command.

The units report events as single-cycle pulses, and each pulse sets a sticky status bit. Software clears these bits by writing ones to them. One registered interrupt line is raised while any event bit is pending and the interrupt mask is clear. The current state of each unit appears in the low byte of the status word. The pointer register drives the address operand that the units use for start and load commands.

Top module: `host_cmd_regs`

## Requirements
- R1: After reset all sticky status bits are 0, both command fields are 0, the mask bit is 1, the pointer is 0 and irq_o is 0.
- R2: A pulse on evt_i bit k, for k in {15,14,13,12,11,10,8}, sets status bit k on the next cycle. The bit stays set until it is acknowledged. Other evt_i bits have no effect, and status bits 9, 1 and 0 always read 0.
- R3: A write to byte offset 0 with byte lane 1 enabled clears every sticky status bit whose data bit (bus bits 15:8 = status 15:8) is 1. Bits written with 0 are unchanged.
- R4: When an event pulse and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: The command unit field is command bits 7:4 (bus bits 23:20 at offset 0, lane 2). Codes: 0 no-op, 1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base, 7 dump and reset. While the field is nonzero, cu_req_o is 1 and cu_code_o carries the field. The field clears on the cycle after cu_ack_i is sampled with cu_req_o high.
- R6: The receive unit field is command bits 2:0 (bus bits 18:16, lane 2). Codes: 0 no-op, 1 start, 2 resume, 4 abort, 6 load base, 7 resume without resources. Request, code and clearing follow R5, using ru_req_o, ru_code_o and ru_ack_i.
- R7: A write to lane 2 replaces both command fields, and this write takes priority over an accept in the same cycle. Command bits 3 and 15:10 read 0.
- R8: Command bit 8 (bus bit 24, lane 3) is the interrupt mask, where 1 means masked, and it reads back. Writing 1 to command bit 9 (bus bit 25, lane 3) sets status bit 10 and reads back as 0.
- R9: irq_o is registered. On each cycle it equals the OR of the sticky status bits ANDed with the inverted mask, taken from the previous cycle.
- R10: Status bits 7:6 show cu_state_i and status bits 5:2 show ru_state_i, combinationally. Receive-unit encodings: 0 idle, 1 suspended, 2 no resources, 4 ready; bit 5 (input bit 3) flags exhausted buffer descriptors.
- R11: The pointer sits at byte offset 4. Each enabled byte lane writes its byte. ptr_o and reads at offset 4 return the stored value.
- R12: A write whose byte enables are all 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Byte address (0: status/command, 4: pointer) |
| reg_be_i | input | 4 | Byte enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| evt_i | input | 16 | Event pulses, one per status bit |
| cu_state_i | input | 2 | Command unit state |
| ru_state_i | input | 4 | Receive unit state |
| cu_req_o | output | 1 | Command unit code valid |
| cu_code_o | output | 4 | Command unit code |
| cu_ack_i | input | 1 | Command unit accepts code |
| ru_req_o | output | 1 | Receive unit code valid |
| ru_code_o | output | 3 | Receive unit code |
| ru_ack_i | input | 1 | Receive unit accepts code |
| ptr_o | output | 32 | General pointer |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets four collisions: an event and an acknowledge on the same bit, a command write and an accept in the same cycle, a mask change while events are pending, and a write with every byte lane off. If the first is handled wrongly, an event is lost. If the second is handled wrongly, a fresh command is dropped or a stale one is reissued. A wrong mask path gives an interrupt one cycle early or late, and a wrong lane decode corrupts the pointer or the command fields. A long random phase also drives unused event bits and unsupported codes. This checks that unused status bits stay at 0 and that any nonzero code is held until it is accepted.

// File: rtl/host_cmd_regs_pkg.sv
package host_cmd_regs_pkg;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned CU_W     = 4;
  localparam int unsigned RU_W     = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BYTES    = DATA_W / 8;
  localparam logic [STAT_W-1:0] ACK_MASK = 16'hFD00;
  localparam int unsigned SWI_BIT  = 10;
  // command word bit positions, seen on the bus at offset 0 (+16)
  localparam int unsigned CMD_OFS  = 16;
  localparam int unsigned CU_LSB   = 4;
  localparam int unsigned RU_LSB   = 0;
  localparam int unsigned MASK_BIT = 8;
  localparam int unsigned SWI_REQ  = 9;
endpackage

// File: rtl/evt_status.sv
module evt_status
  import host_cmd_regs_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] MASK = ACK_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // set after clear: a colliding event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_i) | set_i) & MASK;
  end

  assign stat_o = stat_q;

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(set_i & MASK)) == $past(set_i & MASK)));
  // R2
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~MASK) == '0);
  // R3
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/cmd_slot.sv
module cmd_slot #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_code_i,
  input  logic         ack_i,
  output logic         req_o,
  output logic [W-1:0] code_o
);
  logic [W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            code_q <= '0;
    else if (wr_i)          code_q <= wr_code_i;
    else if (req_o && ack_i) code_q <= '0;
  end

  assign code_o = code_q;
  assign req_o  = |code_q;

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && !wr_i |=> req_o && $stable(code_o));
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !wr_i |=> !req_o);
  // R7
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> code_o == $past(wr_code_i));
endmodule

// File: rtl/host_cmd_regs.sv
module host_cmd_regs
  import host_cmd_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTES-1:0]  reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [1:0]        cu_state_i,
  input  logic [3:0]        ru_state_i,
  output logic              cu_req_o,
  output logic [CU_W-1:0]   cu_code_o,
  input  logic              cu_ack_i,
  output logic              ru_req_o,
  output logic [RU_W-1:0]   ru_code_o,
  input  logic              ru_ack_i,
  output logic [DATA_W-1:0] ptr_o,
  output logic              irq_o
);
  logic wr_ctl, wr_ptr, wr_cmd_lo, wr_cmd_hi;
  logic [STAT_W-1:0] stat, stat_set, stat_clr, stat_word, cmd_word;
  logic mask_q, irq_q;
  logic [DATA_W-1:0] ptr_q;

  assign wr_ctl    = reg_we_i && !reg_addr_i[2];
  assign wr_ptr    = reg_we_i &&  reg_addr_i[2];
  assign wr_cmd_lo = wr_ctl && reg_be_i[2];
  assign wr_cmd_hi = wr_ctl && reg_be_i[3];

  always_comb begin
    stat_clr = '0;
    if (wr_ctl && reg_be_i[1]) stat_clr[15:8] = reg_wdata_i[15:8];
    stat_set = evt_i;
    if (wr_cmd_hi && reg_wdata_i[CMD_OFS+SWI_REQ]) stat_set[SWI_BIT] = 1'b1;
  end

  evt_status #(.W(STAT_W), .MASK(ACK_MASK)) i_evt_status (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (stat_set), .clr_i(stat_clr), .stat_o(stat)
  );

  cmd_slot #(.W(CU_W)) i_cu_slot (
    .clk_i    (clk_i), .rst_ni(rst_ni),
    .wr_i     (wr_cmd_lo),
    .wr_code_i(reg_wdata_i[CMD_OFS+CU_LSB +: CU_W]),
    .ack_i    (cu_ack_i),
    .req_o    (cu_req_o), .code_o(cu_code_o)
  );

  cmd_slot #(.W(RU_W)) i_ru_slot (
    .clk_i    (clk_i), .rst_ni(rst_ni),
    .wr_i     (wr_cmd_lo),
    .wr_code_i(reg_wdata_i[CMD_OFS+RU_LSB +: RU_W]),
    .ack_i    (ru_ack_i),
    .req_o    (ru_req_o), .code_o(ru_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b1;
    else if (wr_cmd_hi) mask_q <= reg_wdata_i[CMD_OFS+MASK_BIT];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_ptr_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       ptr_q[8*b +: 8] <= '0;
      else if (wr_ptr && reg_be_i[b])    ptr_q[8*b +: 8] <= reg_wdata_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|stat) && !mask_q;
  end

  always_comb begin
    stat_word = {stat[15:8], cu_state_i, ru_state_i, 2'b00};
    cmd_word  = '0;
    cmd_word[MASK_BIT] = mask_q;
    cmd_word[CU_LSB +: CU_W] = cu_code_o;
    cmd_word[RU_LSB +: RU_W] = ru_code_o;
    reg_rdata_o = reg_addr_i[2] ? ptr_q : {cmd_word, stat_word};
  end

  assign ptr_o = ptr_q;
  assign irq_o = irq_q;

  // R9
  mask_blocks_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |=> !irq_o);
  // R9
  pending_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q && (stat != '0) |=> irq_o);
  // R12
  no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_be_i == '0 |=> $stable(ptr_o) && $stable(mask_q));
endmodule

// File: tb/test_host_cmd_regs.sv
module test_host_cmd_regs;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [3:0] reg_be_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] evt_i = '0;
  logic [1:0] cu_state_i = '0;
  logic [3:0] ru_state_i = '0;
  logic cu_req_o, ru_req_o, cu_ack_i = 1'b0, ru_ack_i = 1'b0, irq_o;
  logic [3:0] cu_code_o;
  logic [2:0] ru_code_o;
  logic [31:0] ptr_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  host_cmd_regs i_host_cmd_regs (.*);

  // reference model
  logic [15:0] m_stat = '0;
  logic m_mask = 1'b1, m_irq = 1'b0;
  logic [3:0] m_cu = '0;
  logic [2:0] m_ru = '0;
  logic [31:0] m_ptr = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat = '0; m_mask = 1'b1; m_irq = 1'b0; m_cu = '0; m_ru = '0; m_ptr = '0;
    end else begin
      cyc++;
      m_irq = (m_stat != 0) && !m_mask;
      if (m_cu != 0 && cu_ack_i) m_cu = '0;
      if (m_ru != 0 && ru_ack_i) m_ru = '0;
      if (reg_we_i && reg_addr_i[2] == 1'b0) begin
        if (reg_be_i[1]) m_stat = m_stat & ~{reg_wdata_i[15:8], 8'h00};
        if (reg_be_i[2]) begin m_cu = reg_wdata_i[23:20]; m_ru = reg_wdata_i[18:16]; end
        if (reg_be_i[3]) begin
          m_mask = reg_wdata_i[24];
          if (reg_wdata_i[25]) m_stat[10] = 1'b1;
        end
      end
      if (reg_we_i && reg_addr_i[2] == 1'b1)
        for (int b = 0; b < 4; b++) if (reg_be_i[b]) m_ptr[8*b +: 8] = reg_wdata_i[8*b +: 8];
      m_stat = (m_stat | evt_i) & 16'hFD00;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk("R1 cu_req", cu_req_o, 0);
      chk("R1 ru_req", ru_req_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 ptr", ptr_o, 0);
      chk("R1 rdata", reg_rdata_o, reg_addr_i[2] ? 32'h0 :
          {16'h0100, 8'h00, cu_state_i, ru_state_i, 2'b00});
    end else begin
      chk("R5 cu_code", cu_code_o, m_cu);
      chk("R5 cu_req", cu_req_o, m_cu != 0);
      chk("R6 ru_code", ru_code_o, m_ru);
      chk("R6 ru_req", ru_req_o, m_ru != 0);
      chk("R9 irq", irq_o, m_irq);
      chk("R11 ptr", ptr_o, m_ptr);
      if (reg_addr_i[2])
        chk("R11 rdata ptr", reg_rdata_o, m_ptr);
      else
        chk("R2 R3 R7 R8 R10 rdata ctl", reg_rdata_o,
            {6'b0, 1'b0, m_mask, m_cu, 1'b0, m_ru,
             m_stat[15:8], cu_state_i, ru_state_i, 2'b00});
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
    reg_we_i = 0; reg_be_i = '0; evt_i = '0; cu_ack_i = 0; ru_ack_i = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] be, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_be_i = be; reg_wdata_i = d;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1;
    idle(3);
    @(posedge clk_i); #1 rst_ni = 1;
    idle(2);
    // R2 each event bit, including unused ones
    for (int k = 0; k < 16; k++) begin evt_i = 16'(1) << k; step(); end
    idle(2);
    // R3 zero ack has no effect, then partial, then full
    wr(3'd0, 4'b0010, 32'h0000_0000);
    wr(3'd0, 4'b0010, 32'h0000_A100);
    // R12 lanes off
    wr(3'd0, 4'b0000, 32'hFFFF_FFFF);
    wr(3'd4, 4'b0000, 32'hFFFF_FFFF);
    // R8 unmask, R9 irq follows
    wr(3'd0, 4'b1000, 32'h0000_0000);
    idle(2);
    wr(3'd0, 4'b0010, 32'h0000_FF00);
    idle(2);
    // R4 event and ack collide on bit 14
    evt_i = 16'h4000; wr(3'd0, 4'b0010, 32'h0000_4000);
    idle(1);
    wr(3'd0, 4'b0010, 32'h0000_FF00);
    // R8 software interrupt, masked then unmasked
    wr(3'd0, 4'b1000, 32'h0300_0000);
    idle(2);
    wr(3'd0, 4'b1000, 32'h0000_0000);
    idle(2);
    wr(3'd0, 4'b0010, 32'h0000_0400);
    // R5 R6 commands held until accepted
    wr(3'd0, 4'b0100, 32'h0014_0000);
    idle(3);
    cu_ack_i = 1; step();
    idle(2);
    ru_ack_i = 1; step();
    idle(1);
    // R7 write while pending and same-cycle accept
    wr(3'd0, 4'b0100, 32'h0076_0000);
    cu_ack_i = 1; ru_ack_i = 1;
    wr(3'd0, 4'b0100, 32'h0027_0000);
    idle(1);
    cu_ack_i = 1; ru_ack_i = 1; step();
    // R11 pointer byte lanes
    reg_addr_i = 3'd4;
    wr(3'd4, 4'b0001, 32'h1122_3344);
    wr(3'd4, 4'b0110, 32'hAABB_CCDD);
    wr(3'd4, 4'b1111, 32'hDEAD_BEEF);
    // R10 unit states
    for (int s = 0; s < 16; s++) begin
      reg_addr_i = 3'd0; cu_state_i = 2'(s); ru_state_i = 4'(s); step();
    end
    // random mix
    for (int i = 0; i < 2000; i++) begin
      reg_we_i = ($urandom % 4) == 0;
      reg_addr_i = ($urandom % 2) ? 3'd4 : 3'd0;
      reg_be_i = 4'($urandom);
      reg_wdata_i = $urandom;
      evt_i = ($urandom % 3 == 0) ? 16'($urandom) : '0;
      cu_ack_i = $urandom % 2;
      ru_ack_i = $urandom % 2;
      cu_state_i = 2'($urandom);
      ru_state_i = 4'($urandom);
      @(posedge clk_i); #1;
    end
    step();
    idle(2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule